// File: doc/BRIEF.md
# Serial Programming Link Master

This block is the host end of a four-wire serial programming link. It drives the target's reset line, the serial clock and the data line toward the target, and it samples the data line coming back. A local requester issues one command at a time: open a session, load a word into the target's page buffer, commit a page, erase the chip, read a byte, or close the session. The block turns each command into one or more 32-bit instruction frames and reports completion with a one-cycle `done` pulse. A read also returns the byte through `rd_data`.

Opening a session pulses the target reset while the serial clock is held low. The block then waits a settling time and sends the enable instruction. It compares the echo that the target returns during the third byte. If the echo is wrong, it pulses reset again and retries. After a commit or an erase, the block holds off completion for the write time of the selected memory, so the requester cannot start the next write too early. Every delay is a parameter in system clock cycles.

Top module: `prog_link_master`

## Requirements
- R1: After `rst_n` is released, `tgt_rst`, `tgt_sck`, `tgt_mosi`, `err` and `done` are low, and `req_ready` is high.
- R2: Each frame is 32 bits, sent MSB first. `tgt_sck` stays high for exactly HALF_DIV system clocks per bit. `tgt_mosi` changes only while `tgt_sck` is low. `tgt_miso` is captured when `tgt_sck` falls.
- R3: Op 0 (enter) drives `tgt_rst` high for at least RST_CYC clocks and then low. `tgt_sck` stays low for the whole time `tgt_rst` is high.
- R4: After `tgt_rst` falls during enter, at least ENTRY_CYC clocks pass before the first rise of `tgt_sck`. The enable frame is the bytes AC 53 00 00.
- R5: Enter completes with `done` when the byte captured during the third byte of the enable frame equals 0x53. All four bytes of the frame are always shifted, whether or not the echo is correct.
- R6: On a wrong echo, the block pulses `tgt_rst` again and resends the enable frame. After MAX_RETRY retries have failed, `err` rises.
- R7: Op 1 (load) with `req_eeprom`=0 sends two frames, low data byte first: (40, 00, addr mod 2^PAGE_W, data[7:0]) and then (48, 00, addr mod 2^PAGE_W, data[15:8]). With `req_eeprom`=1 it sends the single frame (C1, 00, addr mod 2^PAGE_W, data[7:0]).
- R8: Op 2 (commit) sends (4C for flash or C2 for EEPROM, 00, addr >> PAGE_W, 00).
- R9: After a commit frame, `done` comes no earlier than WAIT_FL clocks (flash) or WAIT_EE clocks (EEPROM) after the last fall of `tgt_sck`. Op 4 (erase) sends AC 80 00 00 and then waits at least WAIT_ER clocks. No new frame starts during any of these waits.
- R10: Op 3 (read) sends (opcode, address high byte, address low byte, 00). The opcode is 20, or 28 when `req_data[0]`=1, or A0 when `req_eeprom`=1. `rd_data` then holds the byte captured during the fourth byte.
- R11: Op 5 (leave) drives `tgt_rst` high and keeps it high until the next enter.
- R12: Once `err` is high it stays high, `req_ready` stays low, and requests start no frame and produce no `done` until `rst_n` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Command request |
| req_ready | output | 1 | Block idle and able to take a command |
| req_op | input | 3 | 0 enter, 1 load, 2 commit, 3 read, 4 erase, 5 leave |
| req_eeprom | input | 1 | Selects EEPROM (1) or flash (0) |
| req_addr | input | ADDR_W | Word or byte address |
| req_data | input | 16 | Load data; bit 0 selects the high byte for a flash read |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Sticky retry-exhaustion flag |
| rd_data | output | 8 | Byte returned by the last read |
| tgt_rst | output | 1 | Reset line to the target |
| tgt_sck | output | 1 | Serial clock to the target |
| tgt_mosi | output | 1 | Serial data to the target |
| tgt_miso | input | 1 | Serial data from the target |

## Verification
The bench builds the block with HALF_DIV=4, RST_CYC=5, ENTRY_CYC=40, WAIT_FL=90, WAIT_EE=72, WAIT_ER=180 and MAX_RETRY=2. With these values, a full frame takes 256 clocks and every post-write hold-off lasts under two hundred clocks. Exhausting all retries then fits into about a thousand clocks. A behavioural target model inside the bench echoes each received byte one byte late. It can corrupt the enable echo once or every time, and it answers reads from a computed memory image. This lets the single-retry path, the fault path and the read path all run in one short run.

// File: rtl/prog_link_pkg.sv
package prog_link_pkg;

    typedef enum logic [2:0] {
        OP_ENTER  = 3'd0,
        OP_LOAD   = 3'd1,
        OP_COMMIT = 3'd2,
        OP_READ   = 3'd3,
        OP_ERASE  = 3'd4,
        OP_LEAVE  = 3'd5
    } op_e;

    typedef enum logic [2:0] {
        F_ENABLE  = 3'd0,
        F_LOAD_LO = 3'd1,
        F_LOAD_HI = 3'd2,
        F_COMMIT  = 3'd3,
        F_READ    = 3'd4,
        F_ERASE   = 3'd5
    } frame_e;

    localparam logic [7:0] B_ENABLE0   = 8'hAC;
    localparam logic [7:0] B_ENABLE1   = 8'h53;
    localparam logic [7:0] ECHO_BYTE   = 8'h53;
    localparam logic [7:0] B_ERASE1    = 8'h80;
    localparam logic [7:0] B_FL_LD_LO  = 8'h40;
    localparam logic [7:0] B_FL_LD_HI  = 8'h48;
    localparam logic [7:0] B_FL_COMMIT = 8'h4C;
    localparam logic [7:0] B_FL_RD_LO  = 8'h20;
    localparam logic [7:0] B_FL_RD_HI  = 8'h28;
    localparam logic [7:0] B_EE_LD     = 8'hC1;
    localparam logic [7:0] B_EE_COMMIT = 8'hC2;
    localparam logic [7:0] B_EE_RD     = 8'hA0;

endpackage

// File: rtl/prog_wait_timer.sv
module prog_wait_timer #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         zero
);
    logic [W-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);

    // R9: an expired hold-off stays expired until reloaded
    assert_hold_expired_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (zero && !load) |=> zero);

endmodule

// File: rtl/prog_link_shift.sv
module prog_link_shift #(
    parameter int HALF_DIV   = 6,
    parameter int FRAME_BITS = 32,
    parameter int RX_BITS    = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  go,
    input  logic [FRAME_BITS-1:0] word,
    input  logic                  miso,
    output logic                  sck,
    output logic                  mosi,
    output logic                  busy,
    output logic                  done,
    output logic [RX_BITS-1:0]    rx
);
    localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam int BIT_W = $clog2(FRAME_BITS);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_DIV - 1);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(FRAME_BITS - 1);

    typedef struct packed {
        logic                  busy;
        logic                  sck;
        logic                  done;
        logic [CNT_W-1:0]      cnt;
        logic [BIT_W-1:0]      bitn;
        logic [FRAME_BITS-1:0] tx;
        logic [RX_BITS-1:0]    rx;
    } sh_t;

    sh_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (go) begin
            d.busy = 1'b1;
            d.sck  = 1'b0;
            d.cnt  = '0;
            d.bitn = '0;
            d.tx   = word;
        end else if (q.busy) begin
            if (q.cnt == CNT_LAST) begin
                d.cnt = '0;
                if (!q.sck) begin
                    d.sck = 1'b1;
                end else begin
                    d.sck = 1'b0;
                    d.rx  = {q.rx[RX_BITS-2:0], miso};
                    if (q.bitn == BIT_LAST) begin
                        d.busy = 1'b0;
                        d.done = 1'b1;
                    end else begin
                        d.bitn = q.bitn + 1'b1;
                        d.tx   = {q.tx[FRAME_BITS-2:0], 1'b0};
                    end
                end
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sck  = q.sck;
    assign mosi = q.busy & q.tx[FRAME_BITS-1];
    assign busy = q.busy;
    assign done = q.done;
    assign rx   = q.rx;

    // R2: data toward the target holds while the clock is high
    assert_mosi_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.sck && $past(q.sck)) |-> $stable(mosi));

    // R2: the clock only toggles inside a frame
    assert_sck_in_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.sck) |-> q.busy);

endmodule

// File: rtl/prog_frame_enc.sv
module prog_frame_enc
    import prog_link_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int PAGE_W = 6
) (
    input  frame_e            sel,
    input  logic              eeprom,
    input  logic              hi_sel,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       data,
    output logic [31:0]       word
);
    localparam logic [15:0] OFF_MASK = (16'd1 << PAGE_W) - 16'd1;

    logic [15:0] addr16;
    logic [15:0] page16;
    logic [7:0]  offs;
    logic [7:0]  rd_op;

    assign addr16 = 16'(addr);
    assign page16 = addr16 >> PAGE_W;
    assign offs   = 8'(addr16 & OFF_MASK);

    always_comb begin
        if (eeprom)      rd_op = B_EE_RD;
        else if (hi_sel) rd_op = B_FL_RD_HI;
        else             rd_op = B_FL_RD_LO;
    end

    always_comb begin
        case (sel)
            F_ENABLE:  word = {B_ENABLE0, B_ENABLE1, 16'h0000};
            F_LOAD_LO: word = {(eeprom ? B_EE_LD : B_FL_LD_LO), 8'h00, offs, data[7:0]};
            F_LOAD_HI: word = {B_FL_LD_HI, 8'h00, offs, data[15:8]};
            F_COMMIT:  word = {(eeprom ? B_EE_COMMIT : B_FL_COMMIT), 8'h00, page16[7:0], 8'h00};
            F_READ:    word = {rd_op, addr16, 8'h00};
            F_ERASE:   word = {B_ENABLE0, B_ERASE1, 16'h0000};
            default:   word = 32'h0;
        endcase
    end

endmodule

// File: rtl/prog_link_master.sv
module prog_link_master
    import prog_link_pkg::*;
#(
    parameter int HALF_DIV  = 6,
    parameter int RST_CYC   = 8,
    parameter int ENTRY_CYC = 1_000_000,
    parameter int WAIT_FL   = 225_000,
    parameter int WAIT_EE   = 180_000,
    parameter int WAIT_ER   = 450_000,
    parameter int MAX_RETRY = 3,
    parameter int ADDR_W    = 13,
    parameter int PAGE_W    = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_op,
    input  logic              req_eeprom,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [15:0]       req_data,
    output logic              done,
    output logic              err,
    output logic [7:0]        rd_data,
    output logic              tgt_rst,
    output logic              tgt_sck,
    output logic              tgt_mosi,
    input  logic              tgt_miso
);
    localparam int FRAME_BITS = 32;
    localparam int RX_BITS    = 16;
    localparam int M1     = (WAIT_FL > WAIT_EE) ? WAIT_FL : WAIT_EE;
    localparam int M2     = (M1 > WAIT_ER) ? M1 : WAIT_ER;
    localparam int M3     = (M2 > ENTRY_CYC) ? M2 : ENTRY_CYC;
    localparam int MAX_T  = (M3 > RST_CYC) ? M3 : RST_CYC;
    localparam int TMR_W  = $clog2(MAX_T + 1);
    localparam int RW     = (MAX_RETRY > 0) ? $clog2(MAX_RETRY + 1) : 1;
    localparam logic [RW-1:0] RETRY_LIM = RW'(MAX_RETRY);

    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_PULSE  = 3'd1,
        S_SETTLE = 3'd2,
        S_LAUNCH = 3'd3,
        S_XFER   = 3'd4,
        S_WAIT   = 3'd5,
        S_FAULT  = 3'd6
    } st_e;

    typedef struct packed {
        st_e               st;
        frame_e            frame;
        logic              eeprom;
        logic [ADDR_W-1:0] addr;
        logic [15:0]       data;
        logic [RW-1:0]     retries;
        logic              tgt_rst;
        logic              done;
        logic              err;
        logic [7:0]        rd;
    } ctl_t;

    ctl_t q, d;

    logic             tmr_load;
    logic [TMR_W-1:0] tmr_val;
    logic             tmr_zero;
    logic             xfer_go;
    logic [31:0]      xfer_word;
    logic             xfer_busy;
    logic             xfer_done;
    logic [RX_BITS-1:0] xfer_rx;

    prog_frame_enc #(
        .ADDR_W (ADDR_W),
        .PAGE_W (PAGE_W)
    ) u_enc (
        .sel    (q.frame),
        .eeprom (q.eeprom),
        .hi_sel (q.data[0]),
        .addr   (q.addr),
        .data   (q.data),
        .word   (xfer_word)
    );

    prog_link_shift #(
        .HALF_DIV   (HALF_DIV),
        .FRAME_BITS (FRAME_BITS),
        .RX_BITS    (RX_BITS)
    ) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (xfer_go),
        .word  (xfer_word),
        .miso  (tgt_miso),
        .sck   (tgt_sck),
        .mosi  (tgt_mosi),
        .busy  (xfer_busy),
        .done  (xfer_done),
        .rx    (xfer_rx)
    );

    prog_wait_timer #(
        .W (TMR_W)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .val   (tmr_val),
        .zero  (tmr_zero)
    );

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        xfer_go  = 1'b0;
        case (q.st)
            S_IDLE: begin
                if (req_valid && !q.err) begin
                    d.eeprom = req_eeprom;
                    d.addr   = req_addr;
                    d.data   = req_data;
                    case (op_e'(req_op))
                        OP_ENTER: begin
                            d.st      = S_PULSE;
                            d.tgt_rst = 1'b1;
                            d.retries = '0;
                            tmr_load  = 1'b1;
                            tmr_val   = TMR_W'(RST_CYC);
                        end
                        OP_LOAD: begin
                            d.frame = F_LOAD_LO;
                            d.st    = S_LAUNCH;
                        end
                        OP_COMMIT: begin
                            d.frame = F_COMMIT;
                            d.st    = S_LAUNCH;
                        end
                        OP_READ: begin
                            d.frame = F_READ;
                            d.st    = S_LAUNCH;
                        end
                        OP_ERASE: begin
                            d.frame = F_ERASE;
                            d.st    = S_LAUNCH;
                        end
                        OP_LEAVE: begin
                            d.tgt_rst = 1'b1;
                            d.done    = 1'b1;
                        end
                        default: d.done = 1'b1;
                    endcase
                end
            end
            S_PULSE: begin
                if (tmr_zero) begin
                    d.tgt_rst = 1'b0;
                    d.st      = S_SETTLE;
                    tmr_load  = 1'b1;
                    tmr_val   = TMR_W'(ENTRY_CYC);
                end
            end
            S_SETTLE: begin
                if (tmr_zero) begin
                    d.frame = F_ENABLE;
                    d.st    = S_LAUNCH;
                end
            end
            S_LAUNCH: begin
                xfer_go = 1'b1;
                d.st    = S_XFER;
            end
            S_XFER: begin
                if (xfer_done) begin
                    case (q.frame)
                        F_ENABLE: begin
                            if (xfer_rx[15:8] == ECHO_BYTE) begin
                                d.done = 1'b1;
                                d.st   = S_IDLE;
                            end else if (q.retries == RETRY_LIM) begin
                                d.err = 1'b1;
                                d.st  = S_FAULT;
                            end else begin
                                d.retries = q.retries + 1'b1;
                                d.tgt_rst = 1'b1;
                                d.st      = S_PULSE;
                                tmr_load  = 1'b1;
                                tmr_val   = TMR_W'(RST_CYC);
                            end
                        end
                        F_LOAD_LO: begin
                            if (q.eeprom) begin
                                d.done = 1'b1;
                                d.st   = S_IDLE;
                            end else begin
                                d.frame = F_LOAD_HI;
                                d.st    = S_LAUNCH;
                            end
                        end
                        F_COMMIT: begin
                            d.st     = S_WAIT;
                            tmr_load = 1'b1;
                            tmr_val  = q.eeprom ? TMR_W'(WAIT_EE) : TMR_W'(WAIT_FL);
                        end
                        F_ERASE: begin
                            d.st     = S_WAIT;
                            tmr_load = 1'b1;
                            tmr_val  = TMR_W'(WAIT_ER);
                        end
                        F_READ: begin
                            d.rd   = xfer_rx[7:0];
                            d.done = 1'b1;
                            d.st   = S_IDLE;
                        end
                        default: begin
                            d.done = 1'b1;
                            d.st   = S_IDLE;
                        end
                    endcase
                end
            end
            S_WAIT: begin
                if (tmr_zero) begin
                    d.done = 1'b1;
                    d.st   = S_IDLE;
                end
            end
            S_FAULT: d.st = S_FAULT;
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign req_ready = (q.st == S_IDLE) && !q.err;
    assign done      = q.done;
    assign err       = q.err;
    assign rd_data   = q.rd;
    assign tgt_rst   = q.tgt_rst;

    // R3: serial lines stay quiet while the target reset is pulsed
    assert_quiet_in_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_PULSE) |-> (!tgt_sck && !tgt_mosi && tgt_rst));

    // R9: the link is idle during any write hold-off
    assert_idle_in_wait_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_WAIT) |-> (!xfer_busy && !tgt_sck));

    // R6: the retry count never passes its limit
    assert_retry_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        q.retries <= RETRY_LIM);

    // R12: a fault is sticky and blocks new commands
    assert_fault_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> (err && !req_ready && !done));

endmodule

// File: tb/test_prog_link_master.sv
module test_prog_link_master;
    localparam int HALF_DIV  = 4;
    localparam int RST_CYC   = 5;
    localparam int ENTRY_CYC = 40;
    localparam int WAIT_FL   = 90;
    localparam int WAIT_EE   = 72;
    localparam int WAIT_ER   = 180;
    localparam int MAX_RETRY = 2;
    localparam int ADDR_W    = 13;
    localparam int PAGE_W    = 6;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [2:0]        req_op = '0;
    logic              req_eeprom = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [15:0]       req_data = '0;
    logic              done, err;
    logic [7:0]        rd_data;
    logic              tgt_rst, tgt_sck, tgt_mosi;
    logic              miso_r = 1'b0;

    prog_link_master #(
        .HALF_DIV (HALF_DIV), .RST_CYC (RST_CYC), .ENTRY_CYC (ENTRY_CYC),
        .WAIT_FL (WAIT_FL), .WAIT_EE (WAIT_EE), .WAIT_ER (WAIT_ER),
        .MAX_RETRY (MAX_RETRY), .ADDR_W (ADDR_W), .PAGE_W (PAGE_W)
    ) i_prog_link_master (
        .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_ready (req_ready),
        .req_op (req_op), .req_eeprom (req_eeprom), .req_addr (req_addr),
        .req_data (req_data), .done (done), .err (err), .rd_data (rd_data),
        .tgt_rst (tgt_rst), .tgt_sck (tgt_sck), .tgt_mosi (tgt_mosi),
        .tgt_miso (miso_r)
    );

    int n_chk = 0;
    int n_bad = 0;
    longint cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string r, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    function automatic logic [7:0] memval(logic [7:0] opc, logic [7:0] ah, logic [7:0] al);
        return al ^ {ah[3:0], ah[7:4]} ^ opc ^ 8'h3C;
    endfunction

    // behavioural target: echoes each byte one byte late
    logic [7:0]  t_cur = '0;
    logic [7:0]  t_out = '0;
    logic [31:0] t_fr  = '0;
    int          t_bits = 0;
    int          t_j, t_k;
    int          corrupt_left = 0;
    bit          corrupt_all = 1'b0;
    logic [31:0] got_q[$];
    logic [31:0] exp_q[$];

    always @(posedge tgt_sck or posedge tgt_rst) begin
        if (tgt_rst) begin
            t_bits = 0;
            t_out  = '0;
            miso_r = 1'b0;
        end else begin
            t_j    = t_bits % 8;
            t_k    = (t_bits / 8) % 4;
            miso_r = t_out[7 - t_j];
            t_cur  = {t_cur[6:0], tgt_mosi};
            t_fr   = {t_fr[30:0], tgt_mosi};
            t_bits = t_bits + 1;
            if (t_j == 7) begin
                t_out = t_cur;
                if (t_k == 1 && t_fr[15:8] == 8'hAC && t_cur == 8'h53 &&
                    (corrupt_all || corrupt_left > 0)) begin
                    t_out = 8'h00;
                    if (corrupt_left > 0) corrupt_left--;
                end
                if (t_k == 2 && (t_fr[23:16] == 8'h20 || t_fr[23:16] == 8'h28 ||
                                 t_fr[23:16] == 8'hA0))
                    t_out = memval(t_fr[23:16], t_fr[15:8], t_fr[7:0]);
                if (t_k == 3) got_q.push_back(t_fr);
            end
        end
    end

    // per-clock link monitor
    logic   p_sck = 1'b0, p_rst = 1'b0, p_mosi = 1'b0;
    longint rst_rise = 0, rst_fall = 0, last_fall = 0;
    int     hi_len = 0;
    bit     armed = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (tgt_rst && !p_rst) rst_rise = cyc;
            if (!tgt_rst && p_rst) begin
                rst_fall = cyc;
                armed    = 1'b1;
                chk(cyc - rst_rise >= RST_CYC, "R3 reset pulse width", cyc - rst_rise, RST_CYC);
            end
            if (tgt_rst && tgt_sck) chk(1'b0, "R3 sck low while reset high", tgt_sck, 0);
            if (tgt_sck && !p_sck) begin
                if (armed) begin
                    chk(cyc - rst_fall >= ENTRY_CYC, "R4 entry settle", cyc - rst_fall, ENTRY_CYC);
                    armed = 1'b0;
                end
                hi_len = 1;
            end else if (tgt_sck) begin
                hi_len++;
                if (tgt_mosi != p_mosi) chk(1'b0, "R2 mosi moved while sck high", tgt_mosi, p_mosi);
            end
            if (!tgt_sck && p_sck) begin
                chk(hi_len == HALF_DIV, "R2 sck high phase", hi_len, HALF_DIV);
                last_fall = cyc;
            end
            p_sck  = tgt_sck;
            p_rst  = tgt_rst;
            p_mosi = tgt_mosi;
        end
    end

    longint t_done = 0;

    task automatic issue(input logic [2:0] op, input logic ee, input logic [ADDR_W-1:0] a,
                         input logic [15:0] dt, input bit wait_done);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid  = 1'b1;
        req_op     = op;
        req_eeprom = ee;
        req_addr   = a;
        req_data   = dt;
        @(negedge clk);
        req_valid = 1'b0;
        if (wait_done) begin
            while (!done) @(negedge clk);
            t_done = cyc;
        end
    endtask

    task automatic check_frames(input string r);
        logic [31:0] g, e;
        chk(got_q.size() == exp_q.size(), r, got_q.size(), exp_q.size());
        while (got_q.size() > 0 && exp_q.size() > 0) begin
            g = got_q.pop_front();
            e = exp_q.pop_front();
            chk(g == e, r, g, e);
        end
        got_q.delete();
        exp_q.delete();
    endtask

    function automatic logic [31:0] ld_frame(logic [7:0] opc, logic [ADDR_W-1:0] a, logic [7:0] b);
        logic [15:0] a16 = 16'(a);
        return {opc, 8'h00, 8'(a16 & ((16'd1 << PAGE_W) - 16'd1)), b};
    endfunction

    initial begin
        logic [ADDR_W-1:0] a;
        logic [15:0] a16;
        logic [7:0]  exp_rd;
        int          dn;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle state after reset
        chk(tgt_rst == 1'b0 && tgt_sck == 1'b0 && tgt_mosi == 1'b0, "R1 link lines low",
            {tgt_rst, tgt_sck, tgt_mosi}, 0);
        chk(req_ready == 1'b1 && err == 1'b0 && done == 1'b0, "R1 ready/err/done",
            {req_ready, err, done}, 3'b100);

        // R4 R5: clean enter
        issue(3'd0, 1'b0, '0, '0, 1'b1);
        exp_q.push_back(32'hAC530000);
        check_frames("R4 enable frame");
        chk(err == 1'b0 && tgt_rst == 1'b0, "R5 enter accepted", {err, tgt_rst}, 0);

        // R6: one wrong echo, then success; all four bytes still sent (R5)
        corrupt_left = 1;
        issue(3'd0, 1'b0, '0, '0, 1'b1);
        exp_q.push_back(32'hAC530000);
        exp_q.push_back(32'hAC530000);
        check_frames("R6 retry after bad echo");
        chk(err == 1'b0, "R6 no error after one retry", err, 0);

        // R7: flash word load, low byte before high byte
        a = 13'h0ABC;
        issue(3'd1, 1'b0, a, 16'hBEEF, 1'b1);
        exp_q.push_back(ld_frame(8'h40, a, 8'hEF));
        exp_q.push_back(ld_frame(8'h48, a, 8'hBE));
        check_frames("R7 flash load");

        // R7: EEPROM byte load
        a = 13'h0047;
        issue(3'd1, 1'b1, a, 16'h12A5, 1'b1);
        exp_q.push_back(ld_frame(8'hC1, a, 8'hA5));
        check_frames("R7 eeprom load");

        // R8 R9: flash commit with hold-off
        a = 13'h0ABC;
        issue(3'd2, 1'b0, a, '0, 1'b1);
        chk(t_done - last_fall >= WAIT_FL, "R9 flash hold-off", t_done - last_fall, WAIT_FL);
        exp_q.push_back({8'h4C, 8'h00, 8'(16'(a) >> PAGE_W), 8'h00});
        check_frames("R8 flash commit");

        // R8 R9: EEPROM commit
        a = 13'h1FC0;
        issue(3'd2, 1'b1, a, '0, 1'b1);
        chk(t_done - last_fall >= WAIT_EE, "R9 eeprom hold-off", t_done - last_fall, WAIT_EE);
        exp_q.push_back({8'hC2, 8'h00, 8'(16'(a) >> PAGE_W), 8'h00});
        check_frames("R8 eeprom commit");

        // R9: erase
        issue(3'd4, 1'b0, '0, '0, 1'b1);
        chk(t_done - last_fall >= WAIT_ER, "R9 erase hold-off", t_done - last_fall, WAIT_ER);
        exp_q.push_back(32'hAC800000);
        check_frames("R9 erase frame");

        // R10: reads in three flavours
        for (int i = 0; i < 3; i++) begin
            logic [7:0] opc;
            a   = (i == 0) ? 13'h0123 : (i == 1) ? 13'h1E5A : 13'h00FF;
            a16 = 16'(a);
            opc = (i == 0) ? 8'h20 : (i == 1) ? 8'h28 : 8'hA0;
            issue(3'd3, (i == 2), a, (i == 1) ? 16'h0001 : 16'h0000, 1'b1);
            exp_rd = memval(opc, a16[15:8], a16[7:0]);
            exp_q.push_back({opc, a16, 8'h00});
            check_frames("R10 read frame");
            chk(rd_data == exp_rd, "R10 read data", rd_data, exp_rd);
        end

        // R11: leave keeps reset high
        issue(3'd5, 1'b0, '0, '0, 1'b1);
        @(negedge clk);
        chk(tgt_rst == 1'b1, "R11 reset released high", tgt_rst, 1);
        repeat (50) @(negedge clk);
        chk(tgt_rst == 1'b1 && got_q.size() == 0, "R11 reset stays high", tgt_rst, 1);

        // R6: echo always wrong -> retries exhausted -> error
        corrupt_all = 1'b1;
        issue(3'd0, 1'b0, '0, '0, 1'b0);
        while (!err) @(negedge clk);
        for (int i = 0; i < MAX_RETRY + 1; i++) exp_q.push_back(32'hAC530000);
        check_frames("R6 attempts before error");
        chk(req_ready == 1'b0, "R6 ready low on error", req_ready, 0);

        // R12: requests ignored while faulted
        dn = 0;
        req_valid = 1'b1;
        req_op    = 3'd1;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (done) dn++;
        end
        req_valid = 1'b0;
        chk(dn == 0, "R12 no done while faulted", dn, 0);
        chk(got_q.size() == 0, "R12 no frame while faulted", got_q.size(), 0);
        chk(err == 1'b1 && req_ready == 1'b0, "R12 error sticky", {err, req_ready}, 2'b10);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog req=all actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule